// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Sequencer

This block is a small byte-wide sequencer. It reads an opcode from code memory and then reads the operand bytes that the opcode calls for, one byte per cycle. It resolves the operand through one of five paths:
- the byte itself (immediate)
- a working register named by low opcode bits
- a direct 8-bit address
- a pointer held in R0 or R1 (indirect)
- a code-memory byte indexed by a 16-bit data pointer plus the accumulator

The result goes into the accumulator, or it is stored at a data address.

Data space is 256 bytes of internal RAM plus a special-function space. The addressing mode decides what the upper 128 addresses mean. A direct access in that range reaches the special-function registers. An indirect access in that range reaches the upper half of RAM. The eight working registers are the first eight RAM bytes.

Code memory lives outside the block. It is read combinationally on `code_addr` / `code_byte`. The block reports each retired instruction with a one-cycle pulse, and it flags opcodes it does not support.

Top module: `opf_top`

## Requirements
- R1: After reset, acc_o=00, carry_o=0, pc_o=0000, done_o=0 and illegal_o=0. The stack-pointer register (direct address 81H) reads 07H, and every other data byte reads 00H.
- R2: An instruction with n operand bytes (n = 0, 1, 2) retires n+2 clock edges after its first cycle. done_o is high for exactly that one cycle. In that cycle acc_o, carry_o and pc_o show its result, and pc_o has advanced by 1+n (mod 2^16).
- R3: Opcode 24H followed by byte d sets acc to (acc+d) mod 256 and sets carry to bit 8 of the 9-bit sum.
- R4: Opcode 1110_1rrr loads acc from working register r. Register r is the same byte as RAM address r (00H–07H).
- R5: Opcode E5H followed by address a loads acc from a direct read. For a<80H the read reaches RAM[a]. For a>=80H it reaches the special-function space:
  - E0H is the accumulator.
  - 81H, 82H (pointer low), 83H (pointer high), A8H and B8H are storage registers.
  - Every other upper address reads 00H and ignores writes.
- R6: Opcode 85H followed by bytes s then d copies the direct read of s into direct address d, using the routing of R5. The source is read before the destination is written, and acc changes only when d=E0H.
- R7: Opcode 1110_011i loads acc from RAM[Ri], where i picks R0 or R1. All 256 RAM bytes are reachable this way, and the special-function space never is.
- R8: Opcode 1010_011i followed by address a writes the direct read of a into RAM[Ri]. The write lands in RAM even when Ri>=80H.
- R9: Opcode 93H loads acc from code address ({83H,82H} + acc) mod 2^16. Carry is unchanged.
- R10: Any other opcode gives illegal_o high for one cycle on the next clock edge. pc_o advances by one, and no data, acc or carry changes.
- R11: The program counter wraps from FFFFH to 0000H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| code_addr | output | 16 | Code-memory byte address |
| code_byte | input | 8 | Code-memory byte at code_addr, same cycle |
| acc_o | output | 8 | Accumulator |
| carry_o | output | 1 | Carry from the last add |
| pc_o | output | 16 | Program counter |
| done_o | output | 1 | One-cycle pulse: an instruction retired |
| illegal_o | output | 1 | One-cycle pulse: an unsupported opcode was skipped |

## Verification
Some rules are checked by assertions on every cycle:
- every execute cycle is followed by a retire pulse
- a retire pulse and an illegal pulse never coincide
- an illegal pulse comes with a one-step PC advance
- only the two-operand copy ever reaches a second operand cycle
- an upper-half RAM write comes only from the indirect store
- the data pointer fetch leaves carry alone
- a RAM or register write lands where it was aimed

Other behaviour can only be shown by the bench's program, run against its reference model:
- the split of the upper 128 addresses between special-function registers and RAM
- the sharing of working registers with RAM
- the source-before-destination order of the copy
- the 16-bit index sum
- the program counter wrapping

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int DW     = 8;
  localparam int PCW    = 16;
  localparam int NREGS  = 8;
  localparam logic [DW-1:0] ACC_ADDR = 8'hE0;

  typedef enum logic [2:0] {
    K_ILL, K_ADDI, K_MOVR, K_MOVD, K_MOVDD, K_MOVI, K_STI, K_MOVC
  } kind_e;

  typedef enum logic [1:0] {S_OPC, S_OP1, S_OP2, S_EXE} phase_e;

  function automatic kind_e kind_of(logic [DW-1:0] op);
    kind_e k;
    if (op == 8'h24)               k = K_ADDI;
    else if (op[7:3] == 5'b11101)  k = K_MOVR;
    else if (op == 8'hE5)          k = K_MOVD;
    else if (op == 8'h85)          k = K_MOVDD;
    else if (op[7:1] == 7'b1110011) k = K_MOVI;
    else if (op[7:1] == 7'b1010011) k = K_STI;
    else if (op == 8'h93)          k = K_MOVC;
    else                           k = K_ILL;
    return k;
  endfunction

  function automatic logic [1:0] operand_count(kind_e k);
    case (k)
      K_ADDI, K_MOVD, K_STI: return 2'd1;
      K_MOVDD:               return 2'd2;
      default:               return 2'd0;
    endcase
  endfunction

  function automatic logic [PCW-1:0] code_index(logic [PCW-1:0] ptr, logic [DW-1:0] a);
    return ptr + {{(PCW-DW){1'b0}}, a};
  endfunction

  function automatic logic [DW:0] add_carry(logic [DW-1:0] a, logic [DW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction
endpackage

// File: rtl/opf_decode.sv
module opf_decode
  import opf_pkg::*;
(
  input  logic [DW-1:0] op,
  output kind_e         kind,
  output logic [1:0]    nopr
);
  always_comb begin
    kind = kind_of(op);
    nopr = operand_count(kind);
  end
endmodule

// File: rtl/opf_iram.sv
module opf_iram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] dir_addr,
  output logic [DW-1:0] dir_data,
  input  logic          ptr_sel,
  output logic [DW-1:0] ptr_data,
  input  logic [AW-1:0] ind_addr,
  output logic [DW-1:0] ind_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign dir_data = mem[dir_addr];
  assign ptr_data = mem[{{(AW-1){1'b0}}, ptr_sel}];
  assign ind_data = mem[ind_addr];

  // R8
  wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/opf_sfr.sv
module opf_sfr #(
  parameter int DW = 8,
  parameter logic [DW-1:0] SP_INIT = 8'h07
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [DW-1:0]   waddr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   raddr,
  output logic [DW-1:0]   rdata,
  output logic [2*DW-1:0] dptr
);
  localparam logic [DW-1:0] A_SP = 8'h81, A_DPL = 8'h82, A_DPH = 8'h83;
  localparam logic [DW-1:0] A_IEN = 8'hA8, A_IPR = 8'hB8;

  logic [DW-1:0] sp, dpl, dph, ien, ipr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= SP_INIT; dpl <= '0; dph <= '0; ien <= '0; ipr <= '0;
    end else if (we) begin
      case (waddr)
        A_SP:  sp  <= wdata;
        A_DPL: dpl <= wdata;
        A_DPH: dph <= wdata;
        A_IEN: ien <= wdata;
        A_IPR: ipr <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (raddr)
      A_SP:    rdata = sp;
      A_DPL:   rdata = dpl;
      A_DPH:   rdata = dph;
      A_IEN:   rdata = ien;
      A_IPR:   rdata = ipr;
      default: rdata = '0;
    endcase
  end

  assign dptr = {dph, dpl};

  // R5
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && waddr == A_SP) |=> sp == $past(sp));
endmodule

// File: rtl/opf_top.sv
module opf_top
  import opf_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  output logic [PCW-1:0] code_addr,
  input  logic [DW-1:0]  code_byte,
  output logic [DW-1:0]  acc_o,
  output logic           carry_o,
  output logic [PCW-1:0] pc_o,
  output logic           done_o,
  output logic           illegal_o
);
  phase_e         st;
  logic [DW-1:0]  opc, b1, b2, acc;
  logic           cy, done_q, ill_q;
  logic [PCW-1:0] pc;

  logic [DW-1:0]  dec_op;
  kind_e          kind;
  logic [1:0]     nopr;

  assign dec_op = (st == S_OPC) ? code_byte : opc;
  opf_decode u_dec (.op(dec_op), .kind(kind), .nopr(nopr));

  // named internal events
  logic exe, wr_go, to_sfr, ram_we, sfr_we, acc_dir_we;
  logic [DW-1:0] dir_ra, dir_rd, ptr_rd, ind_rd, sfr_rd, src_byte, wr_addr;
  logic [2*DW-1:0] dptr;
  logic [DW:0] sum;

  assign exe        = (st == S_EXE);
  assign wr_go      = exe && (kind == K_MOVDD || kind == K_STI);
  assign to_sfr     = (kind == K_MOVDD) && b2[DW-1];
  assign ram_we     = wr_go && !to_sfr;
  assign sfr_we     = wr_go && to_sfr && (b2 != ACC_ADDR);
  assign acc_dir_we = wr_go && to_sfr && (b2 == ACC_ADDR);
  assign wr_addr    = (kind == K_STI) ? ptr_rd : b2;
  assign dir_ra     = (kind == K_MOVR) ? {{(DW-3){1'b0}}, opc[2:0]} : b1;
  assign src_byte   = !b1[DW-1] ? dir_rd : (b1 == ACC_ADDR) ? acc : sfr_rd;
  assign sum        = add_carry(acc, b1);

  opf_iram #(.AW(DW), .DW(DW)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we(ram_we), .waddr(wr_addr), .wdata(src_byte),
    .dir_addr(dir_ra), .dir_data(dir_rd),
    .ptr_sel(opc[0]), .ptr_data(ptr_rd),
    .ind_addr(ptr_rd), .ind_data(ind_rd)
  );

  opf_sfr #(.DW(DW)) u_sfr (
    .clk(clk), .rst_n(rst_n),
    .we(sfr_we), .waddr(b2), .wdata(src_byte),
    .raddr(b1), .rdata(sfr_rd), .dptr(dptr)
  );

  assign code_addr = (exe && kind == K_MOVC) ? code_index(dptr, acc) : pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_OPC; opc <= '0; b1 <= '0; b2 <= '0; acc <= '0;
      cy <= 1'b0; pc <= '0; done_q <= 1'b0; ill_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      case (st)
        S_OPC: begin
          pc <= pc + 1'b1;
          if (kind == K_ILL) ill_q <= 1'b1;
          else begin
            opc <= code_byte;
            st  <= (nopr == 2'd0) ? S_EXE : S_OP1;
          end
        end
        S_OP1: begin
          b1 <= code_byte;
          pc <= pc + 1'b1;
          st <= (nopr == 2'd2) ? S_OP2 : S_EXE;
        end
        S_OP2: begin
          b2 <= code_byte;
          pc <= pc + 1'b1;
          st <= S_EXE;
        end
        default: begin
          done_q <= 1'b1;
          st     <= S_OPC;
          case (kind)
            K_ADDI:  {cy, acc} <= sum;
            K_MOVR:  acc <= dir_rd;
            K_MOVD:  acc <= src_byte;
            K_MOVI:  acc <= ind_rd;
            K_MOVC:  acc <= code_byte;
            K_MOVDD: if (acc_dir_we) acc <= src_byte;
            default: ;
          endcase
        end
      endcase
    end
  end

  assign acc_o     = acc;
  assign carry_o   = cy;
  assign pc_o      = pc;
  assign done_o    = done_q;
  assign illegal_o = ill_q;

  // R10
  ill_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |-> pc == $past(pc) + 16'd1);
  // R2
  exe_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exe |=> done_q);
  // R2
  done_ill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && ill_q));
  // R6
  two_opr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OP2) |-> kind == K_MOVDD);
  // R8
  upper_ram_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && wr_addr[DW-1]) |-> kind == K_STI);
  // R9
  movc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exe && kind == K_MOVC) |=> cy == $past(cy));
endmodule

// File: tb/sim_opf_top.sv
module sim_opf_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] code_addr, pc_o;
  logic [7:0]  code_byte, acc_o;
  logic        carry_o, done_o, illegal_o;

  logic [7:0] prog [0:127];

  function automatic logic [7:0] rb(int a);
    int m;
    m = a & 16'hFFFF;
    if (m < 128) return prog[m];
    if (m == 16'h00FD) return 8'h5A;
    return 8'h00;
  endfunction

  assign code_byte = rb(int'(code_addr));

  opf_top u0 (
    .clk(clk), .rst_n(rst_n), .code_addr(code_addr), .code_byte(code_byte),
    .acc_o(acc_o), .carry_o(carry_o), .pc_o(pc_o),
    .done_o(done_o), .illegal_o(illegal_o)
  );

  int checks = 0;
  int errors = 0;
  int m_ram [256];
  int m_sfr [256];
  int m_acc, m_c, m_pc;
  int pa = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic emit(int b);
    prog[pa] = b[7:0];
    pa++;
  endtask

  function automatic bit implemented(int a);
    return a == 'h81 || a == 'h82 || a == 'h83 || a == 'hA8 || a == 'hB8;
  endfunction

  function automatic int drd(int a);
    if (a < 128) return m_ram[a];
    if (a == 'hE0) return m_acc;
    if (implemented(a)) return m_sfr[a];
    return 0;
  endfunction

  task automatic dwr(int a, int v);
    if (a < 128) m_ram[a] = v;
    else if (a == 'hE0) m_acc = v;
    else if (implemented(a)) m_sfr[a] = v;
  endtask

  // executes one instruction in the reference model
  task automatic model_step(output int len, output bit ill, output string tag);
    int op, x, y, v, s;
    op = rb(m_pc);
    ill = 1'b0;
    if (op == 'h24) begin
      x = rb(m_pc + 1); s = m_acc + x;
      m_acc = s & 255; m_c = s >> 8;
      len = 3; m_pc += 2; tag = "R3";
    end else if ((op & 'hF8) == 'hE8) begin
      m_acc = m_ram[op & 7]; len = 2; m_pc += 1; tag = "R4";
    end else if (op == 'hE5) begin
      x = rb(m_pc + 1); m_acc = drd(x); len = 3; m_pc += 2;
      tag = (x == 'h81) ? "R1" : "R5";
    end else if (op == 'h85) begin
      x = rb(m_pc + 1); y = rb(m_pc + 2);
      v = drd(x); dwr(y, v); len = 4; m_pc += 3; tag = "R6";
    end else if ((op & 'hFE) == 'hE6) begin
      m_acc = m_ram[m_ram[op & 1]]; len = 2; m_pc += 1; tag = "R7";
    end else if ((op & 'hFE) == 'hA6) begin
      v = drd(rb(m_pc + 1)); m_ram[m_ram[op & 1]] = v;
      len = 3; m_pc += 2; tag = "R8";
    end else if (op == 'h93) begin
      x = (m_sfr['h83] * 256 + m_sfr['h82] + m_acc) & 'hFFFF;
      m_acc = rb(x); len = 2; m_pc += 1; tag = "R9";
    end else begin
      tag = (m_pc == 'hFFFF) ? "R11" : "R10";
      ill = 1'b1; len = 1; m_pc += 1;
    end
    m_pc = m_pc & 'hFFFF;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) prog[i] = 8'h00;
    emit('hE5); emit('h81);             // A = SP = 07
    emit('h24); emit('hFB);             // A = 02, C = 1
    emit('h24); emit('h3E);             // A = 40, C = 0
    emit('h85); emit('hE0); emit('h01); // R1 = 40
    emit('hE9);                         // A = R1
    emit('h24); emit('h50);             // A = 90
    emit('h85); emit('hE0); emit('h00); // R0 = 90
    emit('h85); emit('hE0); emit('hA8); // SFR A8 = 90
    emit('h24); emit('h35);             // A = C5
    emit('hA6); emit('hE0);             // RAM[90] = C5 (upper RAM)
    emit('hE6);                         // A = RAM[90]
    emit('hE5); emit('h90);             // unimplemented SFR -> 00
    emit('hE5); emit('hA8);             // A = 90 from SFR
    emit('hE6);                         // RAM[90] again, not SFR
    emit('h85); emit('h00); emit('h30); // RAM30 = R0
    emit('hE5); emit('h30);             // A = 90
    emit('h24); emit('h6F);             // A = FF
    emit('h85); emit('hE0); emit('h82); // pointer low = FF
    emit('h85); emit('hE0); emit('h83); // pointer high = FF
    emit('hA5);                         // unsupported opcode
    emit('h24); emit('hFF);             // A = FE, C = 1
    emit('h93);                         // A = code[FFFF+FE -> 00FD] = 5A
    emit('hE7);                         // A = RAM[R1=40] = 00
    emit('h85); emit('h30); emit('h30); // self copy
    emit('hEB);                         // A = R3 = 00
  end

  initial begin
    int edges, next_evt, len;
    bit ill;
    string tag;
    for (int i = 0; i < 256; i++) begin m_ram[i] = 0; m_sfr[i] = 0; end
    m_sfr['h81] = 7; m_acc = 0; m_c = 0; m_pc = 0;
    repeat (3) @(negedge clk);
    chk("R1", "acc", int'(acc_o), 0);
    chk("R1", "carry", int'(carry_o), 0);
    chk("R1", "pc", int'(pc_o), 0);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "illegal", int'(illegal_o), 0);
    rst_n = 1'b1;
    edges = 0;
    model_step(len, ill, tag);
    next_evt = len;
    while (edges < 66000) begin
      @(posedge clk);
      @(negedge clk);
      edges++;
      if (edges == next_evt) begin
        chk("R2", "done pulse", int'(done_o), ill ? 0 : 1);
        chk(ill ? tag : "R10", "illegal pulse", int'(illegal_o), ill ? 1 : 0);
        chk(tag, "acc", int'(acc_o), m_acc);
        chk(tag, "carry", int'(carry_o), m_c);
        chk(ill ? tag : "R2", "pc", int'(pc_o), m_pc);
        model_step(len, ill, tag);
        next_evt = edges + len;
      end else begin
        chk("R2", "done idle", int'(done_o), 0);
        chk("R10", "illegal idle", int'(illegal_o), 0);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule